// File: doc/BRIEF.md
# TDD and RF Switch Controller

This block turns a per-sample transmit-activity flag into an internal time-division duplex (TDD) state. The state turns on only after transmit activity has lasted a programmed number of samples. It turns off only after activity has been absent for a second, independently programmed number of samples. A delay counter advances on sample-strobe cycles only. If the input returns to the current state before the count completes, the pending change is dropped.

The internal state feeds two consumers. The first is an external TDD pin value, which either follows the internal state (automatic) or takes a manually written bit, and can then be inverted. The second is the RF switch steering. In automatic mode the switches follow the internal state. Otherwise they take static select bits. The control fields come from a register block outside this unit. That register block sets both delay fields to 1 at reset.

Top module: `tdd_rfsw_ctrl`

## Requirements
- R1: With `tx_active` high, `tdd_int` rises at the clock edge that samples the `on_delay`-th consecutive strobe seeing `tx_active` high.
- R2: With `tx_active` low, `tdd_int` falls at the clock edge that samples the `off_delay`-th consecutive strobe seeing `tx_active` low.
- R3: A strobe that sees `tx_active` equal to the current `tdd_int` cancels any pending change, and the delay count starts again from zero.
- R4: Cycles without `smpl_stb` neither advance the delay count nor change `tdd_int`.
- R5: With `ext_auto`=1, `tdd_ext` equals `tdd_int` of the previous cycle. With `ext_auto`=0, it equals `ext_manual` of the previous cycle.
- R6: `ext_invert`=1 inverts `tdd_ext`, and the inversion is applied after the auto/manual choice.
- R7: With `rfsw_auto`=1, `tx_sw` equals the previous `tdd_int`. `rx_sw` is 2'b11 (not connected) while `tdd_int` is high and equals `rx_sw_code` while it is low.
- R8: With `rfsw_auto`=0, `tx_sw` = `tx_sw_sel` (0 selects path 2, 1 selects path 1) and `rx_sw` = `rx_sw_code` (00 wide, 01 low, 10 high, 11 not connected), each one cycle later.
- R9: While `rst_n` is low, all outputs are 0.
- R10: A delay value of 0 acts like 1: the change happens on the first strobe that sees the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smpl_stb | input | 1 | One-cycle sample strobe |
| tx_active | input | 1 | Transmit activity for the current sample |
| on_delay | input | 16 | Samples before turn-on |
| off_delay | input | 16 | Samples before turn-off |
| ext_auto | input | 1 | External TDD follows the internal state |
| ext_manual | input | 1 | Manual external TDD value |
| ext_invert | input | 1 | Invert the external TDD output |
| rfsw_auto | input | 1 | RF switches follow the internal state |
| tx_sw_sel | input | 1 | Static TX switch select |
| rx_sw_code | input | 2 | RX switch code |
| tdd_int | output | 1 | Internal TDD state |
| tdd_ext | output | 1 | External TDD pin value |
| tx_sw | output | 1 | TX switch select |
| rx_sw | output | 2 | RX switch code |

## Verification
The assertions assume that the control fields and `tx_active` are clean synchronous levels and that `smpl_stb` is high for one cycle at a time. They also assume that the delay fields do not change while a count is in progress. The directed stimulus changes inputs only on falling clock edges. It separates strobes by at least one idle cycle and writes new delay values only when the internal state matches `tx_active`. This keeps every check clear of mid-count reprogramming, whose outcome no requirement defines.

// File: rtl/tdd_rf_pkg.sv
package tdd_rf_pkg;
  localparam int unsigned DLY_W  = 16;
  localparam int unsigned RXC_W  = 2;
  typedef logic [RXC_W-1:0] rx_code_t;
  localparam rx_code_t RX_ISOLATE = 2'b11;
endpackage

// File: rtl/tdd_delay_engine.sv
module tdd_delay_engine #(
  parameter int unsigned CNT_W = tdd_rf_pkg::DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smpl_stb,
  input  logic             tx_active,
  input  logic [CNT_W-1:0] on_delay,
  input  logic [CNT_W-1:0] off_delay,
  output logic             tdd_q
);
  localparam int unsigned SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tdd_d;
  logic [CNT_W-1:0] limit;
  logic [SUM_W-1:0] cnt_inc;
  logic             mismatch;

  always_comb begin
    mismatch = (tx_active != tdd_q);
    limit    = tdd_q ? off_delay : on_delay;
    cnt_inc  = {1'b0, cnt_q} + SUM_W'(1);
    cnt_d    = cnt_q;
    tdd_d    = tdd_q;
    if (smpl_stb) begin
      if (!mismatch) begin
        cnt_d = '0;
      end else if (cnt_inc >= {1'b0, limit}) begin
        cnt_d = '0;
        tdd_d = ~tdd_q;
      end else begin
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tdd_q <= 1'b0;
    end else if (smpl_stb) begin
      cnt_q <= cnt_d;
      tdd_q <= tdd_d;
    end
  end

  // R1
  a_r1_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tdd_q) |-> ($past(smpl_stb) && $past(tx_active)));
  // R2
  a_r2_fall_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tdd_q) |-> ($past(smpl_stb) && !$past(tx_active)));
  // R3
  a_r3_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (smpl_stb && (tx_active == tdd_q)) |=> (cnt_q == '0) && $stable(tdd_q));
  // R4
  a_r4_hold_off_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !smpl_stb |=> ($stable(tdd_q) && $stable(cnt_q)));
endmodule

// File: rtl/tdd_rf_outputs.sv
module tdd_rf_outputs
  import tdd_rf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tdd_int,
  input  logic     ext_auto,
  input  logic     ext_manual,
  input  logic     ext_invert,
  input  logic     rfsw_auto,
  input  logic     tx_sw_sel,
  input  rx_code_t rx_sw_code,
  output logic     tdd_ext,
  output logic     tx_sw,
  output rx_code_t rx_sw
);
  logic     ext_d, tx_d;
  rx_code_t rx_d;

  always_comb begin
    ext_d = (ext_auto ? tdd_int : ext_manual) ^ ext_invert;
    if (rfsw_auto) begin
      tx_d = tdd_int;
      rx_d = tdd_int ? RX_ISOLATE : rx_sw_code;
    end else begin
      tx_d = tx_sw_sel;
      rx_d = rx_sw_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdd_ext <= 1'b0;
      tx_sw   <= 1'b0;
      rx_sw   <= '0;
    end else begin
      tdd_ext <= ext_d;
      tx_sw   <= tx_d;
      rx_sw   <= rx_d;
    end
  end

  // R5
  a_r5_auto_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_auto && !ext_invert) |=> (tdd_ext == $past(tdd_int)));
  // R6
  a_r6_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_auto && ext_invert) |=> (tdd_ext != $past(tdd_int)));
  // R7
  a_r7_auto_tx_isolate: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsw_auto && tdd_int) |=> (tx_sw && (rx_sw == RX_ISOLATE)));
  // R8
  a_r8_static_tx: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsw_auto |=> (tx_sw == $past(tx_sw_sel)));
endmodule

// File: rtl/tdd_rfsw_ctrl.sv
module tdd_rfsw_ctrl
  import tdd_rf_pkg::*;
#(
  parameter int unsigned DW = DLY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smpl_stb,
  input  logic          tx_active,
  input  logic [DW-1:0] on_delay,
  input  logic [DW-1:0] off_delay,
  input  logic          ext_auto,
  input  logic          ext_manual,
  input  logic          ext_invert,
  input  logic          rfsw_auto,
  input  logic          tx_sw_sel,
  input  logic [1:0]    rx_sw_code,
  output logic          tdd_int,
  output logic          tdd_ext,
  output logic          tx_sw,
  output logic [1:0]    rx_sw
);
  logic tdd_state;

  tdd_delay_engine #(.CNT_W(DW)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .smpl_stb  (smpl_stb),
    .tx_active (tx_active),
    .on_delay  (on_delay),
    .off_delay (off_delay),
    .tdd_q     (tdd_state)
  );

  tdd_rf_outputs u_outputs (
    .clk        (clk),
    .rst_n      (rst_n),
    .tdd_int    (tdd_state),
    .ext_auto   (ext_auto),
    .ext_manual (ext_manual),
    .ext_invert (ext_invert),
    .rfsw_auto  (rfsw_auto),
    .tx_sw_sel  (tx_sw_sel),
    .rx_sw_code (rx_sw_code),
    .tdd_ext    (tdd_ext),
    .tx_sw      (tx_sw),
    .rx_sw      (rx_sw)
  );

  assign tdd_int = tdd_state;
endmodule

// File: tb/tdd_rfsw_ctrl_bench.sv
module tdd_rfsw_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smpl_stb = 1'b0;
  logic        tx_active = 1'b0;
  logic [15:0] on_delay = 16'd1;
  logic [15:0] off_delay = 16'd1;
  logic        ext_auto = 1'b0, ext_manual = 1'b0, ext_invert = 1'b0;
  logic        rfsw_auto = 1'b0, tx_sw_sel = 1'b0;
  logic [1:0]  rx_sw_code = 2'b00;
  logic        tdd_int, tdd_ext, tx_sw;
  logic [1:0]  rx_sw;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tdd_rfsw_ctrl u_tdd_rfsw_ctrl (
    .clk(clk), .rst_n(rst_n), .smpl_stb(smpl_stb), .tx_active(tx_active),
    .on_delay(on_delay), .off_delay(off_delay), .ext_auto(ext_auto),
    .ext_manual(ext_manual), .ext_invert(ext_invert), .rfsw_auto(rfsw_auto),
    .tx_sw_sel(tx_sw_sel), .rx_sw_code(rx_sw_code), .tdd_int(tdd_int),
    .tdd_ext(tdd_ext), .tx_sw(tx_sw), .rx_sw(rx_sw)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) smpl_stb = 1'b1;
      @(negedge clk) smpl_stb = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 tdd_int", {3'b0, tdd_int}, 4'h0);
    check("R9 tdd_ext", {3'b0, tdd_ext}, 4'h0);
    check("R9 tx_sw", {3'b0, tx_sw}, 4'h0);
    check("R9 rx_sw", {2'b0, rx_sw}, 4'h0);
    @(negedge clk) rst_n = 1'b1;
    settle();
  endtask

  task automatic t_delays();
    on_delay = 16'd3; off_delay = 16'd2;
    tx_active = 1'b1;
    strobes(2);
    check("R1 before on count", {3'b0, tdd_int}, 4'h0);
    repeat (10) @(negedge clk);
    check("R4 idle cycles no advance", {3'b0, tdd_int}, 4'h0);
    strobes(1);
    check("R1 on after 3 strobes", {3'b0, tdd_int}, 4'h1);
    tx_active = 1'b0;
    strobes(1);
    check("R2 before off count", {3'b0, tdd_int}, 4'h1);
    repeat (8) @(negedge clk);
    check("R4 idle hold high", {3'b0, tdd_int}, 4'h1);
    strobes(1);
    check("R2 off after 2 strobes", {3'b0, tdd_int}, 4'h0);
  endtask

  task automatic t_cancel();
    on_delay = 16'd4; off_delay = 16'd3;
    tx_active = 1'b1; strobes(3);
    tx_active = 1'b0; strobes(1);
    check("R3 on cancelled", {3'b0, tdd_int}, 4'h0);
    tx_active = 1'b1; strobes(3);
    check("R3 on count restarted", {3'b0, tdd_int}, 4'h0);
    strobes(1);
    check("R3 on after fresh 4", {3'b0, tdd_int}, 4'h1);
    tx_active = 1'b0; strobes(2);
    tx_active = 1'b1; strobes(1);
    tx_active = 1'b0; strobes(2);
    check("R3 off count restarted", {3'b0, tdd_int}, 4'h1);
    strobes(1);
    check("R3 off after fresh 3", {3'b0, tdd_int}, 4'h0);
  endtask

  task automatic t_short_delays();
    on_delay = 16'd0; off_delay = 16'd1;
    tx_active = 1'b1; strobes(1);
    check("R10 zero delay turns on at once", {3'b0, tdd_int}, 4'h1);
    tx_active = 1'b0; strobes(1);
    check("R10 delay one turns off at once", {3'b0, tdd_int}, 4'h0);
  endtask

  task automatic t_ext_path();
    on_delay = 16'd1; off_delay = 16'd1;
    ext_auto = 1'b1; ext_invert = 1'b0; ext_manual = 1'b0;
    settle();
    check("R5 auto follows low", {3'b0, tdd_ext}, 4'h0);
    tx_active = 1'b1; strobes(1);
    check("R5 auto follows high", {3'b0, tdd_ext}, 4'h1);
    ext_invert = 1'b1; settle();
    check("R6 auto inverted", {3'b0, tdd_ext}, 4'h0);
    ext_auto = 1'b0; ext_invert = 1'b0; ext_manual = 1'b0; settle();
    check("R5 manual zero while tdd high", {3'b0, tdd_ext}, 4'h0);
    ext_invert = 1'b1; settle();
    check("R6 manual zero inverted", {3'b0, tdd_ext}, 4'h1);
    tx_active = 1'b0; strobes(1);
    ext_invert = 1'b0; ext_manual = 1'b1; settle();
    check("R5 manual one while tdd low", {3'b0, tdd_ext}, 4'h1);
    ext_manual = 1'b0; settle();
  endtask

  task automatic t_switches();
    rfsw_auto = 1'b0;
    for (int c = 0; c < 4; c++) begin
      tx_sw_sel = c[0]; rx_sw_code = c[1:0]; settle();
      check("R8 static tx select", {3'b0, tx_sw}, {3'b0, c[0]});
      check("R8 static rx code", {2'b0, rx_sw}, {2'b0, c[1:0]});
    end
    rfsw_auto = 1'b1; tx_sw_sel = 1'b1; rx_sw_code = 2'b10; settle();
    check("R7 auto tx low state", {3'b0, tx_sw}, 4'h0);
    check("R7 auto rx code when low", {2'b0, rx_sw}, 4'h2);
    tx_active = 1'b1; strobes(1);
    check("R7 auto tx high state", {3'b0, tx_sw}, 4'h1);
    check("R7 auto rx isolated", {2'b0, rx_sw}, 4'h3);
    tx_active = 1'b0; strobes(1);
    check("R7 auto rx restored", {2'b0, rx_sw}, 4'h2);
  endtask

  initial begin
    t_reset();
    t_delays();
    t_cancel();
    t_short_delays();
    t_ext_path();
    t_switches();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule